// File: doc/BRIEF.md
# Halfword Pack Decode-Execute Unit

This unit decodes and executes one pack-halfword operation. Each result is built from one 16-bit half of the first register operand and the other 16-bit half of a shifted copy of the second operand. The unit accepts two instruction layouts. The first is a single 32-bit word that carries a condition field. The second is a 32-bit word made of two 16-bit halves. The leading half sits in bits [31:16] and the trailing half in bits [15:0].

From the instruction the unit pulls out the destination and source register indices, a 5-bit shift amount and a select bit. The select bit picks both the shift kind and the half arrangement:
- When the select bit is 0, the second operand is shifted left.
- When the select bit is 1, the second operand is shifted arithmetically right.

The unit also evaluates the condition against the supplied NZCV flags. It raises flags for four cases: an encoding that does not belong to this operation, an undefined encoding, an unpredictable register choice, and a failed condition.

The surrounding pipeline supplies the register values and consumes the indices, the write-enable and the result one cycle after it presents the instruction.

Top module: `halfword_pack_unit`

## Requirements
- R1: With `in_form`=0 the word is decoded as follows:
  - condition in [31:28], first-source index in [19:16], destination index in [15:12], second-source index in [3:0];
  - shift amount in [11:7], select bit in [6];
  - fixed bits [27:20]=01101000 and [5:4]=01.
- R2: With `in_form`=1 the word is decoded as follows:
  - fixed bits [31:21]=11101010110, [20]=S, first-source index in [19:16], fixed bit [15]=0;
  - shift amount = {[14:12],[7:6]}, destination index in [11:8], select bit in [5], [4]=T, second-source index in [3:0].
- R3: `out_nomatch` is raised and `out_wen` is low when any fixed bit differs, or when the condition field is 1111 in form 0.
- R4: In form 1, `out_undef` is raised and `out_wen` is low when S or T is 1. Form 0 never raises `out_undef`.
- R5: With select 0:
  - the second operand is shifted left by the amount, and an amount of 0 means no shift;
  - result[15:0] comes from the first operand and result[31:16] from the shifted second operand.
- R6: With select 1 and an amount of 1 to 31:
  - the second operand is shifted arithmetically right by that amount;
  - result[15:0] comes from the shifted second operand and result[31:16] from the first operand.
- R7: With select 1 and an amount of 0, the shift is by 32, so every bit of the shifted value equals bit 31 of the second operand.
- R8: `out_unpred` is raised when any of the three indices equals 15. It does not gate `out_wen`.
- R9: In form 0 the condition uses the standard codes with flags N=bit3, Z=bit2, C=bit1, V=bit0 of `in_nzcv`:
  - 0 EQ, 1 NE, 2 CS, 3 CC, 4 MI, 5 PL, 6 VS, 7 VC;
  - 8 HI, 9 LS, A GE, B LT, C GT, D LE, E AL.
  - A failed condition raises `out_cond_fail` and drops `out_wen`. Form 1 always passes.
- R10: The carry flag has no effect on the result.
- R11: The outputs appear exactly one cycle after an `in_valid` cycle, with `out_valid` high. In a cycle after no valid input, `out_valid`, `out_wen` and all status flags are low.
- R12: During reset, `out_valid`, `out_wen`, all status flags, the indices and the result are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_insn | input | 32 | Instruction word |
| in_form | input | 1 | Layout select: 0 single word, 1 two halves |
| in_opa | input | 32 | First source register value |
| in_opb | input | 32 | Second source register value |
| in_nzcv | input | 4 | Condition flags N,Z,C,V |
| out_valid | output | 1 | Result present |
| out_rd | output | 4 | Destination index |
| out_rn | output | 4 | First source index |
| out_rm | output | 4 | Second source index |
| out_wen | output | 1 | Register write enable |
| out_result | output | 32 | Packed result |
| out_undef | output | 1 | Undefined encoding |
| out_unpred | output | 1 | An index equals 15 |
| out_cond_fail | output | 1 | Condition failed |
| out_nomatch | output | 1 | Fixed bits do not match |

## Verification
The assertions assume three things about the inputs:
- reset is low for at least one clock edge before checking begins;
- `in_form` stays 0 or 1 and is stable together with the instruction in a valid cycle;
- the operand values are sampled in the same cycle as `in_valid`, because the half-origin properties compare the result with the first operand from one cycle earlier.

The bench keeps to these assumptions. It changes inputs only at the falling edge and holds each instruction for exactly one valid cycle. It puts at least one idle cycle between instructions, so each result can be tied to its own stimulus.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int XLEN     = 32;
  localparam int HALF     = XLEN / 2;
  localparam int IDX_W    = 4;
  localparam int SH_W     = 5;
  localparam int FLAG_W   = 4;
  localparam logic [IDX_W-1:0] PC_IDX = '1;

  typedef enum logic { FORM_WORD = 1'b0, FORM_SPLIT = 1'b1 } hp_form_e;

  typedef struct packed {
    logic [IDX_W-1:0] rd;
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rm;
    logic [SH_W-1:0]  shamt;
    logic             sel;
    logic [3:0]       cond;
    logic             nomatch;
    logic             undef;
  } hp_dec_t;

  // Condition check over N,Z,C,V packed as bits 3..0
  function automatic logic hp_cond_ok(input logic [3:0] cc, input logic [FLAG_W-1:0] f);
    logic n, z, c, v, base;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    unique case (cc[3:1])
      3'd0: base = z;
      3'd1: base = c;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = c & ~z;
      3'd5: base = (n == v);
      3'd6: base = ~z & (n == v);
      default: base = 1'b1;
    endcase
    return (cc[3:1] == 3'd7) ? 1'b1 : (base ^ cc[0]);
  endfunction

  // Left shift, or arithmetic right shift where a zero amount means 32
  function automatic logic [XLEN-1:0] hp_shift(input logic [XLEN-1:0] b,
                                               input logic [SH_W-1:0] amt,
                                               input logic arith);
    logic [XLEN-1:0] r;
    if (!arith)          r = b << amt;
    else if (amt == '0)  r = {XLEN{b[XLEN-1]}};
    else                 r = $signed(b) >>> amt;
    return r;
  endfunction

  function automatic logic [XLEN-1:0] hp_merge(input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] sb,
                                               input logic sel);
    return sel ? {a[XLEN-1:HALF], sb[HALF-1:0]} : {sb[XLEN-1:HALF], a[HALF-1:0]};
  endfunction
endpackage

// File: rtl/hp_decode.sv
module hp_decode
  import hp_pkg::*;
(
  input  logic [XLEN-1:0] insn,
  input  logic            form,
  output hp_dec_t         dec
);
  localparam logic [7:0]  WORD_OPC  = 8'b0110_1000;
  localparam logic [1:0]  WORD_TAIL = 2'b01;
  localparam logic [10:0] SPLIT_OPC = 11'b111_0101_0110;

  hp_dec_t word_d, split_d;

  always_comb begin
    word_d.cond    = insn[31:28];
    word_d.rn      = insn[19:16];
    word_d.rd      = insn[15:12];
    word_d.shamt   = insn[11:7];
    word_d.sel     = insn[6];
    word_d.rm      = insn[3:0];
    word_d.undef   = 1'b0;
    word_d.nomatch = (insn[27:20] != WORD_OPC) || (insn[5:4] != WORD_TAIL)
                     || (insn[31:28] == 4'hF);
  end

  always_comb begin
    split_d.cond    = 4'hE;
    split_d.rn      = insn[19:16];
    split_d.rd      = insn[11:8];
    split_d.shamt   = {insn[14:12], insn[7:6]};
    split_d.sel     = insn[5];
    split_d.rm      = insn[3:0];
    split_d.undef   = insn[20] | insn[4];
    split_d.nomatch = (insn[31:21] != SPLIT_OPC) || insn[15];
  end

  assign dec = (form == FORM_SPLIT) ? split_d : word_d;
endmodule

// File: rtl/hp_cond.sv
module hp_cond
  import hp_pkg::*;
(
  input  logic [3:0]        cond,
  input  logic [FLAG_W-1:0] nzcv,
  output logic              pass
);
  assign pass = hp_cond_ok(cond, nzcv);
endmodule

// File: rtl/hp_pack_dp.sv
module hp_pack_dp
  import hp_pkg::*;
(
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [SH_W-1:0] shamt,
  input  logic            sel,
  output logic [XLEN-1:0] shifted,
  output logic [XLEN-1:0] result
);
  assign shifted = hp_shift(opb, shamt, sel);
  assign result  = hp_merge(opa, shifted, sel);
endmodule

// File: rtl/halfword_pack_unit.sv
module halfword_pack_unit
  import hp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [XLEN-1:0]   in_insn,
  input  logic              in_form,
  input  logic [XLEN-1:0]   in_opa,
  input  logic [XLEN-1:0]   in_opb,
  input  logic [FLAG_W-1:0] in_nzcv,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_rd,
  output logic [IDX_W-1:0]  out_rn,
  output logic [IDX_W-1:0]  out_rm,
  output logic              out_wen,
  output logic [XLEN-1:0]   out_result,
  output logic              out_undef,
  output logic              out_unpred,
  output logic              out_cond_fail,
  output logic              out_nomatch
);
  hp_dec_t         dec;
  logic            cond_pass;
  logic [XLEN-1:0] dp_shifted, dp_result;
  logic            dec_sel, hit_pc, wr_ok;

  hp_decode u_dec (.insn(in_insn), .form(in_form), .dec(dec));
  hp_cond   u_cond(.cond(dec.cond), .nzcv(in_nzcv), .pass(cond_pass));
  hp_pack_dp u_dp (.opa(in_opa), .opb(in_opb), .shamt(dec.shamt), .sel(dec.sel),
                   .shifted(dp_shifted), .result(dp_result));

  assign dec_sel = dec.sel;
  assign hit_pc  = (dec.rd == PC_IDX) || (dec.rn == PC_IDX) || (dec.rm == PC_IDX);
  assign wr_ok   = ~dec.nomatch & ~dec.undef & cond_pass;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_wen       <= 1'b0;
      out_undef     <= 1'b0;
      out_unpred    <= 1'b0;
      out_cond_fail <= 1'b0;
      out_nomatch   <= 1'b0;
      out_rd        <= '0;
      out_rn        <= '0;
      out_rm        <= '0;
      out_result    <= '0;
    end else begin
      out_valid     <= in_valid;
      out_wen       <= in_valid & wr_ok;
      out_undef     <= in_valid & dec.undef;
      out_unpred    <= in_valid & hit_pc;
      out_cond_fail <= in_valid & ~cond_pass;
      out_nomatch   <= in_valid & dec.nomatch;
      if (in_valid) begin
        out_rd     <= dec.rd;
        out_rn     <= dec.rn;
        out_rm     <= dec.rm;
        out_result <= dp_result;
      end
    end
  end
endmodule

// File: rtl/hp_checker.sv
module hp_checker
  import hp_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_form,
  input logic [XLEN-1:0] in_opa,
  input logic            dec_sel,
  input logic            out_valid,
  input logic            out_wen,
  input logic            out_undef,
  input logic            out_unpred,
  input logic            out_cond_fail,
  input logic            out_nomatch,
  input logic [XLEN-1:0] out_result
);
  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_wen && !out_undef && !out_unpred
                  && !out_cond_fail && !out_nomatch);
  // R3
  wen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_wen |-> out_valid && !out_undef && !out_nomatch && !out_cond_fail);
  // R4
  undef_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_form |=> !out_undef);
  // R9
  split_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_form |=> !out_cond_fail);
  // R5
  low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !dec_sel |=> out_result[HALF-1:0] == $past(in_opa[HALF-1:0]));
  // R6
  high_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && dec_sel |=> out_result[XLEN-1:HALF] == $past(in_opa[XLEN-1:HALF]));
endmodule

bind halfword_pack_unit hp_checker u_hp_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_form(in_form),
  .in_opa(in_opa), .dec_sel(dec_sel), .out_valid(out_valid), .out_wen(out_wen),
  .out_undef(out_undef), .out_unpred(out_unpred), .out_cond_fail(out_cond_fail),
  .out_nomatch(out_nomatch), .out_result(out_result)
);

// File: tb/halfword_pack_unit_bench.sv
module halfword_pack_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 93;
  localparam int NV = 16;

  // {form, sel, shamt, cond, rd, rn, rm, S, T, opa, opb, nzcv}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0,1'b0,5'd0, 4'hE,4'd1,4'd2,4'd3,2'b00,32'h1234_5678,32'h9ABC_DEF0,4'h0},
    {1'b0,1'b0,5'd8, 4'hE,4'd0,4'd7,4'd9,2'b00,32'hAAAA_BBBB,32'h00C3_D400,4'h0},
    {1'b0,1'b1,5'd4, 4'hE,4'd5,4'd6,4'd7,2'b00,32'h1357_2468,32'h8000_1234,4'h0},
    {1'b0,1'b1,5'd0, 4'hE,4'd2,4'd3,4'd4,2'b00,32'h0F0F_F0F0,32'h8765_4321,4'h0},
    {1'b0,1'b1,5'd0, 4'hE,4'd2,4'd3,4'd4,2'b00,32'h0F0F_F0F0,32'h7000_0000,4'h0},
    {1'b0,1'b0,5'd31,4'hE,4'd8,4'd9,4'd10,2'b00,32'hCAFE_BABE,32'h0000_0003,4'h0},
    {1'b0,1'b0,5'd2, 4'h0,4'd1,4'd2,4'd3,2'b00,32'h1111_2222,32'h3333_4444,4'h0},
    {1'b0,1'b1,5'd1, 4'hC,4'd1,4'd2,4'd3,2'b00,32'h1111_2222,32'hF000_0010,4'h9},
    {1'b0,1'b0,5'd1, 4'h9,4'd1,4'd2,4'd3,2'b00,32'h1111_2222,32'h0000_8001,4'h2},
    {1'b0,1'b0,5'd1, 4'h8,4'd1,4'd2,4'd3,2'b00,32'h1111_2222,32'h0000_8001,4'h2},
    {1'b1,1'b0,5'd21,4'hE,4'd4,4'd5,4'd6,2'b00,32'h5555_6666,32'h0000_0001,4'h0},
    {1'b1,1'b1,5'd0, 4'hE,4'd4,4'd5,4'd6,2'b00,32'hABCD_0123,32'h9000_0000,4'h0},
    {1'b1,1'b1,5'd3, 4'hE,4'd4,4'd5,4'd6,2'b10,32'hABCD_0123,32'h9000_0000,4'h0},
    {1'b1,1'b0,5'd3, 4'hE,4'd4,4'd5,4'd6,2'b01,32'hABCD_0123,32'h9000_0000,4'h0},
    {1'b0,1'b0,5'd0, 4'hE,4'd15,4'd2,4'd3,2'b00,32'h0000_1111,32'h2222_0000,4'h0},
    {1'b1,1'b1,5'd16,4'hE,4'd1,4'd2,4'd15,2'b00,32'h4444_0000,32'h8000_0000,4'h0}
  };

  logic        clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_form = 1'b0;
  logic [31:0] in_insn = '0, in_opa = '0, in_opb = '0;
  logic [3:0]  in_nzcv = '0;
  logic        out_valid, out_wen, out_undef, out_unpred, out_cond_fail, out_nomatch;
  logic [3:0]  out_rd, out_rn, out_rm;
  logic [31:0] out_result;
  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halfword_pack_unit u_halfword_pack_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn), .in_form(in_form),
    .in_opa(in_opa), .in_opb(in_opb), .in_nzcv(in_nzcv), .out_valid(out_valid),
    .out_rd(out_rd), .out_rn(out_rn), .out_rm(out_rm), .out_wen(out_wen),
    .out_result(out_result), .out_undef(out_undef), .out_unpred(out_unpred),
    .out_cond_fail(out_cond_fail), .out_nomatch(out_nomatch));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_word(input logic [3:0] c, input logic [3:0] rn,
      input logic [3:0] rd, input logic [4:0] sh, input logic sel, input logic [3:0] rm);
    return {c, 8'b0110_1000, rn, rd, sh, sel, 2'b01, rm};
  endfunction

  function automatic logic [31:0] enc_split(input logic s, input logic [3:0] rn,
      input logic [4:0] sh, input logic [3:0] rd, input logic sel, input logic t,
      input logic [3:0] rm);
    return {11'b111_0101_0110, s, rn, 1'b0, sh[4:2], rd, sh[1:0], sel, t, rm};
  endfunction

  // Bench restatement: shift one bit at a time
  function automatic logic [31:0] ref_shift(input logic [31:0] b, input logic [4:0] sh,
                                            input logic sel);
    logic [31:0] r = b;
    int k = sel ? ((sh == 0) ? 32 : int'(sh)) : int'(sh);
    for (int i = 0; i < k; i++) r = sel ? {r[31], r[31:1]} : {r[30:0], 1'b0};
    return r;
  endfunction

  function automatic logic ref_cond(input logic [3:0] c, input logic [3:0] f);
    logic n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      4'h0: return z;            4'h1: return !z;
      4'h2: return cy;           4'h3: return !cy;
      4'h4: return n;            4'h5: return !n;
      4'h6: return v;            4'h7: return !v;
      4'h8: return cy && !z;     4'h9: return !cy || z;
      4'hA: return n == v;       4'hB: return n != v;
      4'hC: return !z && n == v; 4'hD: return z || n != v;
      default: return 1'b1;
    endcase
  endfunction

  // Drive one instruction at a falling edge; sample at the next falling edge
  task automatic issue(input logic form, input logic [31:0] insn, input logic [31:0] a,
                       input logic [31:0] b, input logic [3:0] f);
    @(negedge clk);
    in_valid = 1'b1; in_form = form; in_insn = insn;
    in_opa = a; in_opb = b; in_nzcv = f;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_vec(input logic [VW-1:0] v, input int idx);
    logic form = v[92], sel = v[91], s = v[75], t = v[74];
    logic [4:0] sh = v[90:86];
    logic [3:0] c = v[85:82], rd = v[81:78], rn = v[77:74+0-0+3-3+0], rm = v[73:70];
    logic [31:0] a = v[67:36], b = v[35:4], sb, exp_res;
    logic [3:0] f = v[3:0];
    logic pass, und, unp, wen;
    rn = v[77:74];
    rm = v[73:70];
    s = v[69]; t = v[68];
    sb = ref_shift(b, sh, sel);
    exp_res = sel ? {a[31:16], sb[15:0]} : {sb[31:16], a[15:0]};
    pass = form ? 1'b1 : ref_cond(c, f);
    und = form & (s | t);
    unp = (rd == 15) || (rn == 15) || (rm == 15);
    wen = pass && !und;
    issue(form, form ? enc_split(s, rn, sh, rd, sel, t, rm) : enc_word(c, rn, rd, sh, sel, rm),
          a, b, f);
    check(form ? "R2" : "R1", $sformatf("vec%0d indices", idx),
          {20'd0, out_rd, out_rn, out_rm}, {20'd0, rd, rn, rm});
    check(sel ? ((sh == 0) ? "R7" : "R6") : "R5", $sformatf("vec%0d result", idx),
          out_result, exp_res);
    check("R9", $sformatf("vec%0d cond_fail", idx), {31'd0, out_cond_fail}, {31'd0, !pass});
    check("R4", $sformatf("vec%0d undef", idx), {31'd0, out_undef}, {31'd0, und});
    check("R8", $sformatf("vec%0d unpred", idx), {31'd0, out_unpred}, {31'd0, unp});
    check("R11", $sformatf("vec%0d valid", idx), {31'd0, out_valid}, 32'd1);
    check("R3", $sformatf("vec%0d wen", idx), {30'd0, out_nomatch, out_wen}, {30'd0, 1'b0, wen});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", "reset flags",
          {26'd0, out_valid, out_wen, out_undef, out_unpred, out_cond_fail, out_nomatch}, 32'd0);
    check("R12", "reset result", out_result, 32'd0);
    check("R12", "reset indices", {20'd0, out_rd, out_rn, out_rm}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // R11: idle cycle after a valid one
    @(negedge clk);
    check("R11", "idle valid/wen/flags",
          {26'd0, out_valid, out_wen, out_undef, out_unpred, out_cond_fail, out_nomatch}, 32'd0);

    // R3: wrong fixed byte in single-word form
    issue(1'b0, enc_word(4'hE, 4'd1, 4'd2, 5'd0, 1'b0, 4'd3) ^ 32'h0010_0000,
          32'h1, 32'h2, 4'h0);
    check("R3", "word opcode mismatch", {30'd0, out_nomatch, out_wen}, 32'd2);
    // R3: wrong [5:4]
    issue(1'b0, enc_word(4'hE, 4'd1, 4'd2, 5'd0, 1'b0, 4'd3) ^ 32'h0000_0030,
          32'h1, 32'h2, 4'h0);
    check("R3", "word tail mismatch", {30'd0, out_nomatch, out_wen}, 32'd2);
    // R3: condition 1111
    issue(1'b0, enc_word(4'hF, 4'd1, 4'd2, 5'd0, 1'b0, 4'd3), 32'h1, 32'h2, 4'h0);
    check("R3", "cond 1111", {30'd0, out_nomatch, out_wen}, 32'd2);
    // R3: split form with bit 15 set
    issue(1'b1, enc_split(1'b0, 4'd1, 5'd0, 4'd2, 1'b0, 1'b0, 4'd3) | 32'h0000_8000,
          32'h1, 32'h2, 4'h0);
    check("R3", "split bit15", {30'd0, out_nomatch, out_wen}, 32'd2);
    // R3: split form leading half wrong
    issue(1'b1, enc_split(1'b0, 4'd1, 5'd0, 4'd2, 1'b0, 1'b0, 4'd3) ^ 32'h0040_0000,
          32'h1, 32'h2, 4'h0);
    check("R3", "split opcode mismatch", {30'd0, out_nomatch, out_wen}, 32'd2);

    // R10: carry flag alone changes nothing
    issue(1'b0, enc_word(4'hE, 4'd1, 4'd2, 5'd5, 1'b1, 4'd3), 32'h2468_ACE0, 32'hC001_8003, 4'h0);
    r0 = out_result;
    issue(1'b0, enc_word(4'hE, 4'd1, 4'd2, 5'd5, 1'b1, 4'd3), 32'h2468_ACE0, 32'hC001_8003, 4'h2);
    check("R10", "carry-independent result", out_result, r0);
    check("R10", "carry-independent value", r0, 32'h2468_0C00);

    // R8: unpredictable still writes
    issue(1'b0, enc_word(4'hE, 4'd15, 4'd15, 5'd0, 1'b0, 4'd15), 32'h0, 32'h0, 4'h0);
    check("R8", "all-15 unpred/wen", {30'd0, out_unpred, out_wen}, 32'd3);

    // R12: reset asserted mid-run clears outputs
    @(negedge clk);
    in_valid = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R12", "reset mid-run", {31'd0, out_valid}, 32'd0);
    check("R12", "reset mid-run result", out_result, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule